// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Transmitter

This block is the transmit half of an asynchronous serial port that runs in multiprocessor mode. Every character frame carries one extra marker bit after the data byte. Receivers on a shared line use this bit to tell an address (ID) frame from a data frame. A host loads a byte and the marker bit into a holding register, then commits the frame by clearing a data-empty flag. A DMA-style requester can do the load and the commit in a single write strobe. A programmable divider sets the bit time. Every level change on the line happens on a divider tick.

When the enable bit is raised, the line stays at mark level for one whole frame time before any data may leave. The data-empty flag returns to 1 when a committed frame moves into the shifter. It drives a maskable interrupt request. A transmit-end flag shows that the line has gone quiet with nothing queued. When the enable bit is dropped, any frame in flight is cut off. While the pin is switched to port mode, a port data bit drives the line, and a 0 on that bit holds a break (space) level.

Top module: `mptx_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `txd` is 1, `empty_flag` is 1, `end_flag` is 1 and `tx_irq` is 0.
- R2: A frame is a start bit (0), then the 8 bits of `wr_data` LSB first, then the marker bit `wr_mpb`, then a stop bit (1). Each bit lasts `baud_div`+1 clock cycles.
- R3: After `tx_en` rises, `txd` stays 1 for 11 bit times. A frame committed during that time has its start bit begin 11*(`baud_div`+1) cycles after the rise, within one cycle.
- R4: A `data_wr` or `dma_wr` strobe is taken only while `empty_flag` is 1. A strobe while it is 0 leaves the queued byte and marker unchanged.
- R5: A `flag_clr` pulse while `empty_flag` is 1 and `tx_en` is 1 commits the held frame, and `empty_flag` reads 0 on the next cycle. `empty_flag` goes back to 1 in the cycle the start bit of that frame appears.
- R6: A `dma_wr` strobe while `empty_flag` is 1 loads the data and commits the frame in the same access, and `empty_flag` reads 0 on the next cycle.
- R7: `tx_irq` is 1 exactly when `tie_en` was 1 in the previous cycle and `empty_flag` is 1. Otherwise it is 0.
- R8: Committing a frame clears `end_flag` to 0. `end_flag` is set to 1 at the end of a stop bit when no frame is queued. `end_flag` is never 1 while `empty_flag` is 0.
- R9: A frame committed before the current stop bit ends starts right after that stop bit. The start bits of the two frames are exactly 11*(`baud_div`+1) cycles apart.
- R10: Lowering `tx_en` in the middle of a frame brings `txd` (with `port_sel` 0) to 1, and `empty_flag` and `end_flag` to 1, within two cycles. Commits made while `tx_en` is 0 have no effect on `empty_flag`.
- R11: While `port_sel` is 1, `txd` follows `port_bit` with one cycle of delay. Holding `port_bit` at 0 gives a continuous break level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable bit |
| tie_en | input | 1 | Transmit interrupt enable bit |
| baud_div | input | DIV_W | Bit time minus one, in clock cycles |
| wr_data | input | DATA_W | Byte to load into the holding register |
| wr_mpb | input | 1 | Marker bit to load with the byte (1 = ID frame) |
| data_wr | input | 1 | Host write strobe for the holding register |
| dma_wr | input | 1 | DMA write strobe: loads and commits together |
| flag_clr | input | 1 | Host clear of the data-empty flag (commits the frame) |
| port_sel | input | 1 | Pin in port mode: line driven from port_bit |
| port_bit | input | 1 | Port data bit driven on the line in port mode |
| txd | output | 1 | Serial line output, registered |
| empty_flag | output | 1 | Holding register free for a new write |
| end_flag | output | 1 | All committed frames fully sent |
| tx_irq | output | 1 | Data-empty interrupt request, registered |

## Verification
The assertions assume that `baud_div` changes only while `tx_en` is 0. They also assume that `wr_data` and `wr_mpb` are valid in the cycle of a write strobe. The stimulus picks a new random divisor only after it has lowered the enable bit, and it drives data and strobe together on the same falling edge. The random writers wait for `empty_flag` before each write. The only deliberate write to a busy register is the directed R4 case, which the assertions allow for.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_PRE  = 2'd1,
    ST_IDLE = 2'd2,
    ST_SEND = 2'd3
  } tx_state_e;

  function automatic int frame_bits(input int data_w);
    return data_w + 3;
  endfunction
endpackage

// File: rtl/mptx_baud.sv
module mptx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && run && $stable(div)) |=> !tick || (div == '0));
endmodule

// File: rtl/mptx_regs.sv
module mptx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tie_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              data_wr,
  input  logic              dma_wr,
  input  logic              flag_clr,
  input  logic              load_i,
  input  logic              done_i,
  output logic              empty_o,
  output logic              end_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] hold_data_o,
  output logic              hold_mpb_o
);
  logic accept, commit, empty_d, end_d;

  assign accept = (data_wr || dma_wr) && empty_o;
  assign commit = tx_en && empty_o && (flag_clr || dma_wr);

  always_comb begin
    empty_d = empty_o;
    end_d   = end_o;
    if (!tx_en) begin
      empty_d = 1'b1;
      end_d   = 1'b1;
    end else if (load_i) begin
      empty_d = 1'b1;
    end else if (commit) begin
      empty_d = 1'b0;
      end_d   = 1'b0;
    end else if (done_i) begin
      end_d   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_o     <= 1'b1;
      end_o       <= 1'b1;
      irq_o       <= 1'b0;
      hold_data_o <= '0;
      hold_mpb_o  <= 1'b0;
    end else begin
      empty_o <= empty_d;
      end_o   <= end_d;
      irq_o   <= tie_en && empty_d;
      if (accept) begin
        hold_data_o <= wr_data;
        hold_mpb_o  <= wr_mpb;
      end
    end
  end

  assert_busy_write_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    ((data_wr || dma_wr) && !empty_o) |=> $stable(hold_data_o) && $stable(hold_mpb_o));

  assert_end_needs_empty_R8: assert property (@(posedge clk) disable iff (rst)
    end_o |-> empty_o);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(tie_en) |-> !irq_o);

  assert_irq_needs_empty_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> empty_o);
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tick,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              hold_mpb_i,
  input  logic              port_sel,
  input  logic              port_bit,
  output logic              load_o,
  output logic              done_o,
  output logic              txd_o
);
  localparam int SR_W     = DATA_W + 2;
  localparam int LAST_IDX = frame_bits(DATA_W) - 1;
  localparam int CNT_W    = $clog2(LAST_IDX + 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SR_W-1:0]  sr_q, sr_d;
  logic             ser_q, ser_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    ser_d   = ser_q;
    load_o  = 1'b0;
    done_o  = 1'b0;
    if (!tx_en) begin
      state_d = ST_OFF;
      cnt_d   = '0;
      ser_d   = 1'b1;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_d = ST_PRE;
          cnt_d   = '0;
          ser_d   = 1'b1;
        end
        default: begin
          if (tick) begin
            if (state_q != ST_IDLE && cnt_q != CNT_W'(LAST_IDX)) begin
              cnt_d = cnt_q + 1'b1;
              if (state_q == ST_SEND) begin
                ser_d = sr_q[0];
                sr_d  = {1'b1, sr_q[SR_W-1:1]};
              end
            end else if (!empty_i) begin
              load_o  = 1'b1;
              state_d = ST_SEND;
              cnt_d   = '0;
              ser_d   = 1'b0;
              sr_d    = {1'b1, hold_mpb_i, hold_data_i};
            end else begin
              done_o  = (state_q == ST_SEND);
              state_d = ST_IDLE;
              ser_d   = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      sr_q    <= '1;
      ser_q   <= 1'b1;
      txd_o   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      ser_q   <= ser_d;
      txd_o   <= port_sel ? port_bit : ser_d;
    end
  end

  assert_preamble_mark_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRE) |-> ser_q);

  assert_load_refills_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (load_o && tx_en) |=> empty_i);

  assert_abort_to_mark_R10: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (state_q == ST_OFF) && ser_q);

  assert_port_follow_R11: assert property (@(posedge clk) disable iff (rst)
    port_sel |=> (txd_o == $past(port_bit)));
endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tie_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              data_wr,
  input  logic              dma_wr,
  input  logic              flag_clr,
  input  logic              port_sel,
  input  logic              port_bit,
  output logic              txd,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              tx_irq
);
  logic              tick, load, done, hold_mpb;
  logic [DATA_W-1:0] hold_data;

  mptx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk (clk),
    .rst (rst),
    .run (tx_en),
    .div (baud_div),
    .tick(tick)
  );

  mptx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .tie_en     (tie_en),
    .wr_data    (wr_data),
    .wr_mpb     (wr_mpb),
    .data_wr    (data_wr),
    .dma_wr     (dma_wr),
    .flag_clr   (flag_clr),
    .load_i     (load),
    .done_i     (done),
    .empty_o    (empty_flag),
    .end_o      (end_flag),
    .irq_o      (tx_irq),
    .hold_data_o(hold_data),
    .hold_mpb_o (hold_mpb)
  );

  mptx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .tick       (tick),
    .empty_i    (empty_flag),
    .hold_data_i(hold_data),
    .hold_mpb_i (hold_mpb),
    .port_sel   (port_sel),
    .port_bit   (port_bit),
    .load_o     (load),
    .done_o     (done),
    .txd_o      (txd)
  );
endmodule

// File: tb/test_mptx_top.sv
module test_mptx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0, tie_en = 1'b0;
  logic [11:0] baud_div = 12'd3;
  logic [7:0]  wr_data = '0;
  logic        wr_mpb = 1'b0, data_wr = 1'b0, dma_wr = 1'b0, flag_clr = 1'b0;
  logic        port_sel = 1'b0, port_bit = 1'b1;
  logic        txd, empty_flag, end_flag, tx_irq;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mptx_top i_mptx_top (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tie_en(tie_en), .baud_div(baud_div),
    .wr_data(wr_data), .wr_mpb(wr_mpb), .data_wr(data_wr), .dma_wr(dma_wr),
    .flag_clr(flag_clr), .port_sel(port_sel), .port_bit(port_bit),
    .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int bit_time(input int dv);
    return dv + 1;
  endfunction

  function automatic int frame_time(input int dv);
    return 11 * bit_time(dv);
  endfunction

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic m, input bit use_dma);
    @(negedge clk);
    while (!empty_flag) @(negedge clk);
    wr_data = d;
    wr_mpb  = m;
    if (use_dma) begin
      dma_wr = 1'b1;
      @(negedge clk);
      dma_wr = 1'b0;
      chk(empty_flag == 1'b0, "R6", empty_flag, 0);
    end else begin
      data_wr = 1'b1;
      @(negedge clk);
      data_wr  = 1'b0;
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(empty_flag == 1'b0, "R5", empty_flag, 0);
    end
    chk(end_flag == 1'b0, "R8 commit clears end", end_flag, 0);
    chk(tx_irq == 1'b0, "R7 no irq while full", tx_irq, 0);
  endtask

  // decode one frame; last=1 also checks the end flag after the stop bit
  task automatic decode(input int dv, input logic [7:0] ed, input logic em,
                        input bit last, output int t0);
    logic [7:0] got;
    logic       gm, sb;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    chk(empty_flag == 1'b1, "R5 empty at start", empty_flag, 1);
    wait_cycles(dv / 2);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    for (int j = 0; j < 8; j++) begin
      wait_cycles(bit_time(dv));
      got[j] = txd;
    end
    wait_cycles(bit_time(dv));
    gm = txd;
    wait_cycles(bit_time(dv));
    sb = txd;
    chk(got == ed, "R2 data byte", got, ed);
    chk(gm == em, "R2 marker bit", gm, em);
    chk(sb == 1'b1, "R2 stop bit", sb, 1);
    if (last) begin
      chk(end_flag == 1'b0, "R8 end low in stop", end_flag, 0);
      wait_cycles(bit_time(dv));
      chk(end_flag == 1'b1, "R8 end after stop", end_flag, 1);
      chk(txd == 1'b1, "R8 line idle", txd, 1);
    end
  endtask

  task automatic burst(input int dv, input int n, input bit inject, input bit irq_on);
    logic [7:0] ed [4];
    logic       em [4];
    bit         dm [4];
    int         t_en;
    tx_en = 1'b0;
    wait_cycles(2);
    baud_div = 12'(dv);
    tie_en   = irq_on;
    for (int k = 0; k < n; k++) begin
      ed[k] = 8'($urandom_range(0, 255));
      em[k] = 1'($urandom_range(0, 1));
      dm[k] = 1'($urandom_range(0, 1));
    end
    t_en  = cyc;
    tx_en = 1'b1;
    wait_cycles(2);
    chk(tx_irq == irq_on, "R7 irq follows enable", tx_irq, irq_on);
    fork
      begin
        for (int k = 0; k < n; k++) begin
          send(ed[k], em[k], dm[k]);
          if (inject && k == 1) begin
            wr_data = ~ed[k];
            wr_mpb  = ~em[k];
            data_wr = 1'b1;
            @(negedge clk);
            data_wr = 1'b0;
            chk(empty_flag == 1'b0, "R4 busy write keeps flag", empty_flag, 0);
          end
        end
      end
      begin
        int t0, tp;
        tp = 0;
        for (int k = 0; k < n; k++) begin
          decode(dv, ed[k], em[k], k == n - 1, t0);
          if (k == 0) begin
            chk((t0 - t_en) >= frame_time(dv) - 1 && (t0 - t_en) <= frame_time(dv) + 1,
                "R3 idle frame on enable", t0 - t_en, frame_time(dv));
          end else begin
            chk((t0 - tp) == frame_time(dv), "R9 back-to-back spacing", t0 - tp, frame_time(dv));
          end
          tp = t0;
        end
      end
    join
  endtask

  initial begin
    int seen_one;
    void'($urandom(32'd2024));
    wait_cycles(4);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(empty_flag == 1'b1, "R1 empty", empty_flag, 1);
    chk(end_flag == 1'b1, "R1 end", end_flag, 1);
    chk(tx_irq == 1'b0, "R1 irq", tx_irq, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && empty_flag && end_flag && !tx_irq, "R1 after reset",
        {txd, empty_flag, end_flag, tx_irq}, 4'b1110);

    // directed: single host frame, smallest divisor used
    burst(2, 1, 1'b0, 1'b1);
    // directed: busy write must be dropped (R4)
    burst(5, 3, 1'b1, 1'b0);
    // random bursts
    for (int b = 0; b < 8; b++) begin
      burst($urandom_range(2, 8), $urandom_range(1, 3), 1'b0, 1'($urandom_range(0, 1)));
    end

    // R10: abort mid-frame
    burst(4, 1, 1'b0, 1'b0);
    send(8'h3C, 1'b1, 1'b0);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    wait_cycles(17);
    tx_en = 1'b0;
    wait_cycles(2);
    chk(txd == 1'b1, "R10 line to mark", txd, 1);
    chk(empty_flag == 1'b1, "R10 empty set", empty_flag, 1);
    chk(end_flag == 1'b1, "R10 end set", end_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_cycles(1);
    chk(empty_flag == 1'b1, "R10 clear ignored while off", empty_flag, 1);

    // R11: port override and break
    port_sel = 1'b1;
    port_bit = 1'b0;
    wait_cycles(2);
    chk(txd == 1'b0, "R11 break level", txd, 0);
    seen_one = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd) seen_one++;
    end
    chk(seen_one == 0, "R11 break held", seen_one, 0);
    port_bit = 1'b1;
    wait_cycles(2);
    chk(txd == 1'b1, "R11 port bit high", txd, 1);
    port_sel = 1'b0;
    wait_cycles(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule